// File: doc/BRIEF.md
# Read-Capture Delay Tap Calibrator

This block finds a good setting for the read-data capture delay of a memory interface. On a start pulse it steps a 6-bit delay tap from 0 up to 63. For each tap it drives the same value to all four byte-lane delay lines and starts an external memory self-test. It waits for that test to finish, judges the result and then stops the test. The first and last passing taps are recorded, along with the number of taps that passed.

When the sweep ends, the block takes the midpoint of the first and last passing taps and drives it to every lane. It raises a done flag and keeps the result until the next start. If no tap passed, a fixed fallback tap of 8 is used instead. The block is meant to run once after memory bring-up and whenever the capture window needs to be measured again.

The pass test is strict. A tap passes only when the self-test reports no failed runs and the number of passing runs equals the run count that was configured.

Top module: `rdcap_tap_calibrator`

## Requirements
- R1: After reset, done_o is 0, bist_en_o is 0, every lane tap is 0 and pass_cnt_o is 0.
- R2: All four lane tap fields of lane_tap_o carry the same value in every cycle. Lane k occupies bits [6k+5:6k].
- R3: A sweep starts exactly 64 self-tests, on taps 0, 1, 2 … 63 in that order. The lane taps stay constant while bist_en_o is high.
- R4: In status_i, bit 0 marks test completion. When bit 0 is seen high while bist_en_o is high, bist_en_o drops in the next cycle, and this happens before the tap changes.
- R5: A tap passes only if status_i bits 16:9 (failed runs) are zero and status_i bits 8:1 (passed runs) equal run_cfg_i. A fail-free result with too few or too many passed runs does not pass.
- R6: pass_cnt_o counts the passing taps of the current sweep. It rises by at most one per cycle and never falls, except on a restart.
- R7: When at least one tap passed, the final tap is (first passing tap + last passing tap) >> 1, kept to 6 bits.
- R8: When no tap passed, the final tap is 8.
- R9: At the end of a sweep, done_o rises and the final tap appears on final_tap_o and on all lanes. Both are held until the next start. A start pulse in the middle of a sweep is ignored.
- R10: A start while done_o is high begins a new sweep. The next cycle shows done_o low and pass_cnt_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; begins a sweep when idle or done |
| run_cfg_i | input | 8 | Configured number of self-test runs per tap |
| status_i | input | 17 | Self-test status: bit 0 completion, 8:1 passed runs, 16:9 failed runs |
| bist_en_o | output | 1 | Self-test run enable |
| lane_tap_o | output | 24 | Delay tap for four byte lanes, 6 bits each |
| done_o | output | 1 | Calibration complete |
| final_tap_o | output | 6 | Chosen tap |
| pass_cnt_o | output | 7 | Number of passing taps in the sweep |

## Verification
Some properties are checked on every cycle by the assertions:
- the lanes stay identical;
- the tap stays still during a test;
- the enable drops one cycle after completion;
- the done state and its tap are held;
- the pass counter only steps up by one;
- a restart clears done and the count.

The remaining behaviours are visible only through the bench scenarios. These are the test order across all 64 taps, the strict pass decision, and the midpoint or fallback result. The bench exercises them with eye patterns built from full, empty, single-edge, narrow, gapped and random windows, with pass-count mismatches placed outside the eye.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;
    // Sweep sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_RUN,
        ST_SAMPLE,
        ST_STEP,
        ST_CENTER,
        ST_HOLD
    } cal_state_e;

    // Status word layout: completion flag, passed-run and failed-run counts
    localparam int STS_DONE_BIT = 0;
    localparam int STS_PASS_LSB = 1;
endpackage

// File: rtl/rdcap_pass_judge.sv
module rdcap_pass_judge #(
    parameter int CNT_W = 8
) (
    input  logic [2*CNT_W:0]  status_i,
    input  logic [CNT_W:1]    want_i,
    output logic              sts_done_o,
    output logic              pass_o
);
    import rdcap_pkg::*;
    localparam int FAIL_LSB = STS_PASS_LSB + CNT_W;

    logic [CNT_W-1:0] runs_ok;
    logic [CNT_W-1:0] runs_bad;

    always_comb begin
        sts_done_o = status_i[STS_DONE_BIT];
        runs_ok    = status_i[STS_PASS_LSB +: CNT_W];
        runs_bad   = status_i[FAIL_LSB +: CNT_W];
        pass_o     = sts_done_o && (runs_bad == '0) && (runs_ok == want_i);
    end
endmodule

// File: rtl/rdcap_center_pick.sv
module rdcap_center_pick #(
    parameter int TAP_W       = 6,
    parameter int DEFAULT_TAP = 8
) (
    input  logic             found_i,
    input  logic [TAP_W-1:0] first_i,
    input  logic [TAP_W-1:0] last_i,
    output logic [TAP_W-1:0] tap_o
);
    logic [TAP_W:0] sum;

    always_comb begin
        sum   = {1'b0, first_i} + {1'b0, last_i};
        tap_o = found_i ? sum[TAP_W:1] : TAP_W'(DEFAULT_TAP);
    end
endmodule

// File: rtl/rdcap_lane_fanout.sv
module rdcap_lane_fanout #(
    parameter int TAP_W = 6,
    parameter int LANES = 4
) (
    input  logic [TAP_W-1:0]       tap_i,
    output logic [LANES*TAP_W-1:0] lanes_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes_o[g*TAP_W +: TAP_W] = tap_i;
    end
endmodule

// File: rtl/rdcap_tap_calibrator.sv
module rdcap_tap_calibrator #(
    parameter int TAP_W       = 6,
    parameter int LANES       = 4,
    parameter int CNT_W       = 8,
    parameter int DEFAULT_TAP = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [CNT_W:1]         run_cfg_i,
    input  logic [2*CNT_W:0]       status_i,
    output logic                   bist_en_o,
    output logic [LANES*TAP_W-1:0] lane_tap_o,
    output logic                   done_o,
    output logic [TAP_W-1:0]       final_tap_o,
    output logic [TAP_W:0]         pass_cnt_o
);
    import rdcap_pkg::*;

    localparam int PCNT_W = TAP_W + 1;
    localparam logic [TAP_W-1:0] TAP_LAST = '1;

    typedef struct packed {
        cal_state_e        state;
        logic [TAP_W-1:0]  tap;
        logic [TAP_W-1:0]  first;
        logic [TAP_W-1:0]  last;
        logic              found;
        logic [PCNT_W-1:0] pcnt;
        logic              en;
        logic              done;
        logic [TAP_W-1:0]  fin;
    } cal_regs_t;

    cal_regs_t r_q, r_d;

    logic             sts_done;
    logic             tap_pass;
    logic [TAP_W-1:0] center;

    rdcap_pass_judge #(.CNT_W(CNT_W)) u_judge (
        .status_i   (status_i),
        .want_i     (run_cfg_i),
        .sts_done_o (sts_done),
        .pass_o     (tap_pass)
    );

    rdcap_center_pick #(.TAP_W(TAP_W), .DEFAULT_TAP(DEFAULT_TAP)) u_center (
        .found_i (r_q.found),
        .first_i (r_q.first),
        .last_i  (r_q.last),
        .tap_o   (center)
    );

    rdcap_lane_fanout #(.TAP_W(TAP_W), .LANES(LANES)) u_fanout (
        .tap_i   (r_q.tap),
        .lanes_o (lane_tap_o)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE, ST_HOLD: begin
                if (start_i) begin
                    r_d.state = ST_APPLY;
                    r_d.tap   = '0;
                    r_d.first = '0;
                    r_d.last  = '0;
                    r_d.found = 1'b0;
                    r_d.pcnt  = '0;
                    r_d.en    = 1'b0;
                    r_d.done  = 1'b0;
                    r_d.fin   = '0;
                end
            end
            ST_APPLY: begin
                r_d.en    = 1'b1;
                r_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (sts_done) begin
                    r_d.en    = 1'b0;
                    r_d.state = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (tap_pass) begin
                    r_d.pcnt = r_q.pcnt + 1'b1;
                    r_d.last = r_q.tap;
                    if (!r_q.found) begin
                        r_d.first = r_q.tap;
                        r_d.found = 1'b1;
                    end
                end
                r_d.state = ST_STEP;
            end
            ST_STEP: begin
                if (r_q.tap == TAP_LAST) begin
                    r_d.state = ST_CENTER;
                end else begin
                    r_d.tap   = r_q.tap + 1'b1;
                    r_d.state = ST_APPLY;
                end
            end
            ST_CENTER: begin
                r_d.tap   = center;
                r_d.fin   = center;
                r_d.done  = 1'b1;
                r_d.state = ST_HOLD;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bist_en_o   = r_q.en;
    assign done_o      = r_q.done;
    assign final_tap_o = r_q.fin;
    assign pass_cnt_o  = r_q.pcnt;
endmodule

// File: rtl/rdcap_cal_checker.sv
module rdcap_cal_checker #(
    parameter int TAP_W = 6,
    parameter int LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   sts_done_i,
    input logic                   bist_en_o,
    input logic [LANES*TAP_W-1:0] lane_tap_o,
    input logic                   done_o,
    input logic [TAP_W-1:0]       final_tap_o,
    input logic [TAP_W:0]         pass_cnt_o
);
    for (genvar g = 1; g < LANES; g++) begin : g_match
        assert_lane_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
            lane_tap_o[g*TAP_W +: TAP_W] == lane_tap_o[TAP_W-1:0]);
    end

    assert_tap_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bist_en_o && $past(bist_en_o) |-> $stable(lane_tap_o));

    assert_bist_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bist_en_o && sts_done_i |=> !bist_en_o && $stable(lane_tap_o));

    assert_pcnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (pass_cnt_o == $past(pass_cnt_o)) ||
                     (pass_cnt_o == $past(pass_cnt_o) + 1'b1));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(final_tap_o));

    assert_final_on_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> lane_tap_o[TAP_W-1:0] == final_tap_o && !bist_en_o);

    assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && start_i |=> !done_o && pass_cnt_o == '0);
endmodule

bind rdcap_tap_calibrator rdcap_cal_checker #(.TAP_W(TAP_W), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sts_done_i  (status_i[0]),
    .bist_en_o   (bist_en_o),
    .lane_tap_o  (lane_tap_o),
    .done_o      (done_o),
    .final_tap_o (final_tap_o),
    .pass_cnt_o  (pass_cnt_o)
);

// File: tb/rdcap_tap_calibrator_test.sv
`timescale 1ns/1ps
module rdcap_tap_calibrator_test;
    localparam int TAP_W = 6;
    localparam int LANES = 4;
    localparam int NT    = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:1]  run_cfg = '0;
    logic [16:0] status = '0;
    logic        bist_en;
    logic [LANES*TAP_W-1:0] lanes;
    logic        done;
    logic [5:0]  fin;
    logic [6:0]  pcnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    int kind [NT];        // 0 pass, 1 failed runs, 2 short pass count, 3 long pass count
    int run_n = 10;
    int exp_idx = 0;
    bit en_prev = 0;
    logic [7:0] ecnt = '0;
    int lat = 2;

    always #2 clk = ~clk;

    rdcap_tap_calibrator uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .run_cfg_i(run_cfg),
        .status_i(status), .bist_en_o(bist_en), .lane_tap_o(lanes),
        .done_o(done), .final_tap_o(fin), .pass_cnt_o(pcnt)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] make_status(int t);
        logic [7:0] p, f;
        p = 8'(run_n);
        f = 8'd0;
        case (kind[t])
            1: f = 8'(1 + ($urandom % 200));
            2: p = 8'(run_n - 1);
            3: p = 8'(run_n + 1);
            default: ;
        endcase
        return {f, p, 1'b1};
    endfunction

    // Self-test engine model
    always @(posedge clk) begin
        if (!rst_n || !bist_en) begin
            ecnt   <= '0;
            status <= '0;
            lat    <= 1 + int'($urandom % 4);
        end else begin
            ecnt <= ecnt + 1'b1;
            if (ecnt == 8'(lat)) status <= make_status(int'(lanes[TAP_W-1:0]));
        end
    end

    // Test order monitor (R3)
    always @(negedge clk) begin
        if (bist_en && !en_prev) begin
            chk(int'(lanes[TAP_W-1:0]) == exp_idx, "R3", "tap order", int'(lanes[TAP_W-1:0]), exp_idx);
            exp_idx++;
        end
        en_prev = bist_en;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int exp_count();
        int c = 0;
        for (int t = 0; t < NT; t++) if (kind[t] == 0) c++;
        return c;
    endfunction

    function automatic int exp_final();
        int f = -1, l = -1;
        for (int t = 0; t < NT; t++) if (kind[t] == 0) begin
            if (f < 0) f = t;
            l = t;
        end
        if (f < 0) return 8;
        return ((f + l) >> 1) & 63;
    endfunction

    function automatic int bad_kind();
        return 1 + int'($urandom % 3);
    endfunction

    task automatic sweep(string name, bit mid_start);
        int guard;
        int ef, ec;
        run_n = 2 + int'($urandom % 199);
        run_cfg = 8'(run_n);
        ef = exp_final();
        ec = exp_count();
        @(negedge clk);
        start = 1'b1;
        exp_idx = 0;
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R10", {name, " done cleared"}, int'(done), 0);
        chk(pcnt == 0, "R10", {name, " count cleared"}, int'(pcnt), 0);
        if (mid_start) begin
            repeat (120) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_idx == NT, "R3", {name, " tests run"}, exp_idx, NT);
        chk(int'(fin) == ef, (ec == 0) ? "R8" : "R7", {name, " final tap"}, int'(fin), ef);
        chk(int'(pcnt) == ec, "R6", {name, " pass count"}, int'(pcnt), ec);
        for (int g = 0; g < LANES; g++)
            chk(lanes[g*TAP_W +: TAP_W] == fin, "R9", {name, " lane final"},
                int'(lanes[g*TAP_W +: TAP_W]), int'(fin));
        repeat (15) @(negedge clk);
        chk(done && int'(fin) == ef, "R9", {name, " held"}, int'(fin), ef);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int t = 0; t < NT; t++) kind[t] = 1;
        repeat (3) @(negedge clk);
        chk(!done && !bist_en && lanes == '0 && pcnt == 0, "R1", "reset state", int'(lanes), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !bist_en && lanes == '0 && pcnt == 0, "R1", "after reset", int'(pcnt), 0);

        // all fail
        for (int t = 0; t < NT; t++) kind[t] = bad_kind();
        sweep("none", 0);
        // all pass
        for (int t = 0; t < NT; t++) kind[t] = 0;
        sweep("all", 0);
        // only tap 0
        for (int t = 0; t < NT; t++) kind[t] = (t == 0) ? 0 : bad_kind();
        sweep("lo edge", 0);
        // only tap 63
        for (int t = 0; t < NT; t++) kind[t] = (t == 63) ? 0 : bad_kind();
        sweep("hi edge", 0);
        // taps 62 and 63
        for (int t = 0; t < NT; t++) kind[t] = (t >= 62) ? 0 : 1;
        sweep("top pair", 0);
        // fail-free but wrong pass counts everywhere: strict judge (R5)
        for (int t = 0; t < NT; t++) kind[t] = 2 + (t % 2);
        sweep("mismatch", 0);
        chk(pcnt == 0, "R5", "mismatch rejected", int'(pcnt), 0);
        // one passing tap among mismatches (R5)
        for (int t = 0; t < NT; t++) kind[t] = (t == 40) ? 0 : 2 + (t % 2);
        sweep("single", 0);
        chk(pcnt == 1 && fin == 6'd40, "R5", "single pass", int'(fin), 40);
        // random windows, one with a start pulse mid-sweep
        for (int k = 0; k < 4; k++) begin
            int lo = int'($urandom % 64);
            int hi = lo + int'($urandom % (64 - lo));
            for (int t = 0; t < NT; t++) kind[t] = (t >= lo && t <= hi) ? 0 : bad_kind();
            sweep("window", k == 1);
        end
        // gapped eyes
        for (int k = 0; k < 3; k++) begin
            for (int t = 0; t < NT; t++) kind[t] = ($urandom % 4 == 0) ? 0 : bad_kind();
            sweep("gapped", 0);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule